// File: doc/BRIEF.md
# DDR SDRAM Command Decoder and Bank-State Tracker

This block sits on the device side of a DDR SDRAM command bus. On every rising clock edge it samples the active-low chip select, row strobe, column strobe and write enable, the bank address, the address bus and clock enable. From these it decodes the command being issued. For each of four banks it keeps an idle or open state and the row that is open. It also follows the device through power-down and self-refresh.

The outputs are registered and valid one cycle after the sampling edge:
- a one-hot command strobe;
- the bank and row, column or op-code that go with the command;
- the set of banks closed by a precharge;
- an auto-precharge flag for reads and writes;
- separate load strobes for the base and the extended mode register;
- an illegal-command flag;
- the power state.

A controller model or a protocol monitor can use these outputs as a single picture of what the device believes its banks are doing. Checking of timing parameters, the storage array and the data path are not part of this block.

Top module: `ddr_cmd_tracker`

## Requirements
- R1: A synchronous active-high `rst` sampled high makes all banks idle with stored rows of 0, sets the power state to normal (0), and clears every strobe and flag from the following cycle on.
- R2: The command code is {cs_n, ras_n, cas_n, we_n}, sampled on the rising edge, with these encodings: 0111 NOP, 0011 activate, 0101 read, 0100 write, 0010 precharge, 0001 refresh, 0000 mode load and 0110 burst stop. Any code with cs_n high is a NOP. A NOP raises no strobe and changes no state. Refresh raises strobe bit 4. Each result appears on the outputs one cycle after the sampling edge. `cmd_stb` bit positions are: 0 activate, 1 read, 2 write, 3 precharge, 4 refresh, 5 mode load, 6 burst stop.
- R3: Activate to an idle bank `ba` raises strobe bit 0, reports `ba` and the row on `addr`, and marks that bank open with that row.
- R4: Read or write to an open bank raises strobe bit 1 or 2. It reports the column as `addr` with bit 10 cleared. `auto_pre` is set to address bit 10. When bit 10 is 1, that bank becomes idle.
- R5: Precharge raises strobe bit 3. With address bit 10 low it closes only bank `ba`, and `pre_mask` is one-hot on that bank. With bit 10 high it closes all banks, and `pre_mask` is all ones. Precharge of an idle bank is legal.
- R6: Mode load raises strobe bit 5 and reports the op-code on `cmd_addr`. It pulses `mr_base_ld` when ba[0] is 0 and `mr_ext_ld` when ba[0] is 1.
- R7: The following commands raise `cmd_err` with no strobe and leave all bank states unchanged: activate to an open bank, read or write to an idle bank, and refresh while any bank is open (with clock enable high or low).
- R8: In the normal state, clock enable sampled low causes power-down entry, and the command sampled with it is not decoded. The new state is refresh code with all banks idle → self-refresh (3); any other command with all banks idle → precharge power-down (1); any bank open → active power-down (2).
- R9: In either power-down state no command is decoded. Clock enable sampled high returns the state to normal (0) at that edge, and the command sampled at that exit edge is also ignored.
- R10: In self-refresh no command is decoded. `pwr_state` shows normal (0) as soon as clock enable goes high, without waiting for a clock edge. The command sampled at the exit edge is ignored.
- R11: Burst stop raises strobe bit 6 and changes no bank state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W (2) | Bank address |
| addr | input | ADDR_W (13) | Row, column or op-code; bit AP_BIT (10) selects precharge scope and auto-precharge |
| cmd_stb | output | 7 | One-hot decoded command strobe |
| cmd_bank | output | BA_W | Bank of the reported command |
| cmd_addr | output | ADDR_W | Row, column (bit 10 cleared) or op-code |
| pre_mask | output | 4 | Banks closed by the reported precharge |
| auto_pre | output | 1 | Read or write carries auto-precharge |
| mr_base_ld | output | 1 | Base mode register load strobe |
| mr_ext_ld | output | 1 | Extended mode register load strobe |
| cmd_err | output | 1 | Illegal command for the current bank state |
| pwr_state | output | 2 | 0 normal, 1 precharge power-down, 2 active power-down, 3 self-refresh |
| bank_open | output | 4 | Per-bank open flag |
| bank_row | output | 4*ADDR_W | Open row per bank, bank 0 in the low bits |

## Verification
Any corruption of a bank's open flag shows up within one cycle on `bank_open`. It also shows up on the next command to that bank, because the command's legality flips: an activate that should be legal raises `cmd_err`, or a read that should raise `cmd_err` produces a strobe instead. A wrong power state shows either at once on `pwr_state` or as a strobe that appears or disappears on the cycle after the next edge. A wrong stored row is visible on `bank_row` on the cycle after the activate. The bench models the banks and the power state, checks every output after every edge, and checks the self-refresh exit between edges.

// File: rtl/ddr_trk_pkg.sv
package ddr_trk_pkg;

    typedef enum logic [2:0] {
        CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_REF, CMD_LMR, CMD_BST
    } cmd_e;

    typedef enum logic [1:0] {
        PWR_NORM = 2'd0,
        PWR_PPD  = 2'd1,
        PWR_APD  = 2'd2,
        PWR_SREF = 2'd3
    } pwr_e;

    localparam int STB_ACT = 0;
    localparam int STB_RD  = 1;
    localparam int STB_WR  = 2;
    localparam int STB_PRE = 3;
    localparam int STB_REF = 4;
    localparam int STB_LMR = 5;
    localparam int STB_BST = 6;
    localparam int STB_N   = 7;

endpackage

// File: rtl/ddr_trk_decode.sv
module ddr_trk_decode
    import ddr_trk_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    always_comb begin
        if (cs_n) begin
            cmd = CMD_NOP;               // deselected: everything masked
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b010:  cmd = CMD_PRE;
                3'b001:  cmd = CMD_REF;
                3'b000:  cmd = CMD_LMR;
                3'b110:  cmd = CMD_BST;
                default: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/ddr_trk_bank.sv
module ddr_trk_bank #(
    parameter int ROW_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             open_en,
    input  logic             close_en,
    input  logic [ROW_W-1:0] row_in,
    output logic             is_open,
    output logic [ROW_W-1:0] row
);

    typedef struct packed {
        logic             open;
        logic [ROW_W-1:0] row;
    } bank_t;

    bank_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (close_en) begin
            s_d.open = 1'b0;
        end
        if (open_en) begin
            s_d.open = 1'b1;
            s_d.row  = row_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign is_open = s_q.open;
    assign row     = s_q.row;

endmodule

// File: rtl/ddr_cmd_tracker.sv
module ddr_cmd_tracker
    import ddr_trk_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int BA_W   = 2,
    parameter int AP_BIT = 10
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cke,
    input  logic                          cs_n,
    input  logic                          ras_n,
    input  logic                          cas_n,
    input  logic                          we_n,
    input  logic [BA_W-1:0]               ba,
    input  logic [ADDR_W-1:0]             addr,
    output logic [STB_N-1:0]              cmd_stb,
    output logic [BA_W-1:0]               cmd_bank,
    output logic [ADDR_W-1:0]             cmd_addr,
    output logic [(1<<BA_W)-1:0]          pre_mask,
    output logic                          auto_pre,
    output logic                          mr_base_ld,
    output logic                          mr_ext_ld,
    output logic                          cmd_err,
    output logic [1:0]                    pwr_state,
    output logic [(1<<BA_W)-1:0]          bank_open,
    output logic [(1<<BA_W)*ADDR_W-1:0]   bank_row
);

    localparam int BANKS = 1 << BA_W;

    typedef struct packed {
        logic [STB_N-1:0]  stb;
        logic [BA_W-1:0]   bank;
        logic [ADDR_W-1:0] addr;
        logic [BANKS-1:0]  pmask;
        logic              ap;
        logic              mb;
        logic              me;
        logic              err;
        pwr_e              pwr;
    } trk_t;

    trk_t             r_d, r_q;
    cmd_e             cmd;
    logic [BANKS-1:0] open_en;
    logic [BANKS-1:0] close_en;
    logic [BANKS-1:0] open_vec;
    logic [BANKS-1:0] ba_dec;
    logic             any_open;

    ddr_trk_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    for (genvar g = 0; g < BANKS; g++) begin : g_bank
        ddr_trk_bank #(.ROW_W(ADDR_W)) u_bank (
            .clk      (clk),
            .rst      (rst),
            .open_en  (open_en[g]),
            .close_en (close_en[g]),
            .row_in   (addr),
            .is_open  (open_vec[g]),
            .row      (bank_row[g*ADDR_W +: ADDR_W])
        );
    end

    assign any_open = |open_vec;
    assign ba_dec   = {{(BANKS-1){1'b0}}, 1'b1} << ba;

    always_comb begin
        r_d       = r_q;
        r_d.stb   = '0;
        r_d.pmask = '0;
        r_d.ap    = 1'b0;
        r_d.mb    = 1'b0;
        r_d.me    = 1'b0;
        r_d.err   = 1'b0;
        r_d.bank  = ba;
        r_d.addr  = addr;
        open_en   = '0;
        close_en  = '0;
        unique case (r_q.pwr)
            PWR_NORM: begin
                if (!cke) begin
                    // power-down entry: the command itself is not decoded
                    if (cmd == CMD_REF && any_open) begin
                        r_d.err = 1'b1;
                    end
                    if (cmd == CMD_REF && !any_open) begin
                        r_d.pwr = PWR_SREF;
                    end else if (any_open) begin
                        r_d.pwr = PWR_APD;
                    end else begin
                        r_d.pwr = PWR_PPD;
                    end
                end else begin
                    unique case (cmd)
                        CMD_ACT: begin
                            if (open_vec[ba]) begin
                                r_d.err = 1'b1;
                            end else begin
                                r_d.stb[STB_ACT] = 1'b1;
                                open_en          = ba_dec;
                            end
                        end
                        CMD_RD, CMD_WR: begin
                            r_d.addr[AP_BIT] = 1'b0;
                            if (!open_vec[ba]) begin
                                r_d.err = 1'b1;
                            end else begin
                                r_d.stb[(cmd == CMD_RD) ? STB_RD : STB_WR] = 1'b1;
                                r_d.ap = addr[AP_BIT];
                                if (addr[AP_BIT]) begin
                                    close_en = ba_dec;
                                end
                            end
                        end
                        CMD_PRE: begin
                            r_d.stb[STB_PRE] = 1'b1;
                            r_d.pmask        = addr[AP_BIT] ? '1 : ba_dec;
                            close_en         = r_d.pmask;
                        end
                        CMD_REF: begin
                            if (any_open) begin
                                r_d.err = 1'b1;
                            end else begin
                                r_d.stb[STB_REF] = 1'b1;
                            end
                        end
                        CMD_LMR: begin
                            r_d.stb[STB_LMR] = 1'b1;
                            r_d.mb           = ~ba[0];
                            r_d.me           = ba[0];
                        end
                        CMD_BST: begin
                            r_d.stb[STB_BST] = 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
            default: begin
                // power-down or self-refresh: only clock enable is watched
                if (cke) begin
                    r_d.pwr = PWR_NORM;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd_stb    = r_q.stb;
    assign cmd_bank   = r_q.bank;
    assign cmd_addr   = r_q.addr;
    assign pre_mask   = r_q.pmask;
    assign auto_pre   = r_q.ap;
    assign mr_base_ld = r_q.mb;
    assign mr_ext_ld  = r_q.me;
    assign cmd_err    = r_q.err;
    assign bank_open  = open_vec;
    // self-refresh exit follows clock enable without waiting for an edge
    assign pwr_state  = (r_q.pwr == PWR_SREF && cke) ? PWR_NORM : r_q.pwr;

endmodule

// File: rtl/ddr_cmd_tracker_chk.sv
module ddr_cmd_tracker_chk
    import ddr_trk_pkg::*;
#(
    parameter int BA_W = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic [STB_N-1:0]     cmd_stb,
    input logic [BA_W-1:0]      cmd_bank,
    input logic [(1<<BA_W)-1:0] pre_mask,
    input logic                 auto_pre,
    input logic                 mr_base_ld,
    input logic                 mr_ext_ld,
    input logic                 cmd_err,
    input logic [1:0]           pwr_state,
    input logic [(1<<BA_W)-1:0] bank_open
);

    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (bank_open == '0 && cmd_stb == '0 && !cmd_err && pwr_state == 2'd0));

    a_r2_stb_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cmd_stb));

    a_r3_act_opens: assert property (@(posedge clk) disable iff (rst)
        cmd_stb[STB_ACT] |-> bank_open[cmd_bank]);

    a_r4_ap_closes: assert property (@(posedge clk) disable iff (rst)
        ((cmd_stb[STB_RD] || cmd_stb[STB_WR]) && auto_pre) |-> !bank_open[cmd_bank]);

    a_r4_plain_stays_open: assert property (@(posedge clk) disable iff (rst)
        ((cmd_stb[STB_RD] || cmd_stb[STB_WR]) && !auto_pre) |-> bank_open[cmd_bank]);

    a_r5_pre_closed: assert property (@(posedge clk) disable iff (rst)
        cmd_stb[STB_PRE] |-> ((bank_open & pre_mask) == '0 && pre_mask != '0));

    a_r6_mr_strobe: assert property (@(posedge clk) disable iff (rst)
        (mr_base_ld || mr_ext_ld) |-> (cmd_stb[STB_LMR] && !(mr_base_ld && mr_ext_ld)));

    a_r7_err_no_stb: assert property (@(posedge clk) disable iff (rst)
        cmd_err |-> (cmd_stb == '0));

    a_r7_err_keeps_banks: assert property (@(posedge clk) disable iff (rst)
        cmd_err |-> (bank_open == $past(bank_open)));

    a_r9_pd_no_cmd: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == 2'd1 || pwr_state == 2'd2) |=> (cmd_stb == '0));

    a_r10_sref_no_cmd: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == 2'd3) |=> (cmd_stb == '0));

endmodule

bind ddr_cmd_tracker ddr_cmd_tracker_chk #(.BA_W(BA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_stb    (cmd_stb),
    .cmd_bank   (cmd_bank),
    .pre_mask   (pre_mask),
    .auto_pre   (auto_pre),
    .mr_base_ld (mr_base_ld),
    .mr_ext_ld  (mr_ext_ld),
    .cmd_err    (cmd_err),
    .pwr_state  (pwr_state),
    .bank_open  (bank_open)
);

// File: tb/test_ddr_cmd_tracker.sv
`timescale 1ns/1ps
module test_ddr_cmd_tracker;

    localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD  = 4'b0101,
                           C_WR  = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001,
                           C_LMR = 4'b0000, C_BST = 4'b0110;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cke = 1'b1;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic [12:0] addr = '0;
    logic [6:0]  cmd_stb;
    logic [1:0]  cmd_bank;
    logic [12:0] cmd_addr;
    logic [3:0]  pre_mask;
    logic        auto_pre, mr_base_ld, mr_ext_ld, cmd_err;
    logic [1:0]  pwr_state;
    logic [3:0]  bank_open;
    logic [51:0] bank_row;

    int checks = 0;
    int errors = 0;
    logic        m_open [4];
    logic [12:0] m_row  [4];
    logic [1:0]  m_pwr;

    always #2.5 clk = ~clk;

    ddr_cmd_tracker i_ddr_cmd_tracker (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
        .cmd_stb(cmd_stb), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
        .pre_mask(pre_mask), .auto_pre(auto_pre), .mr_base_ld(mr_base_ld),
        .mr_ext_ld(mr_ext_ld), .cmd_err(cmd_err), .pwr_state(pwr_state),
        .bank_open(bank_open), .bank_row(bank_row)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] open_vec();
        logic [3:0] v;
        for (int i = 0; i < 4; i++) v[i] = m_open[i];
        return v;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cke = 1'b1; {cs_n, ras_n, cas_n, we_n} = C_NOP;
        @(posedge clk); #1;
        for (int i = 0; i < 4; i++) begin m_open[i] = 1'b0; m_row[i] = '0; end
        m_pwr = 2'd0;
        chk("R1 strobe", cmd_stb, 0);
        chk("R1 err", cmd_err, 0);
        chk("R1 pwr", pwr_state, 0);
        chk("R1 banks", bank_open, 0);
        chk("R1 rows", bank_row, 0);
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic step(input logic k, input logic [3:0] c, input logic [1:0] b, input logic [12:0] a);
        logic [6:0]  e_stb = '0;
        logic        e_err = 1'b0, e_ap = 1'b0, e_mb = 1'b0, e_me = 1'b0;
        logic [3:0]  e_pm = '0;
        logic [12:0] e_addr = a;
        logic        anyo = |open_vec();
        logic [1:0]  n_pwr = m_pwr;
        string       tag = "R2";
        @(negedge clk);
        cke = k; {cs_n, ras_n, cas_n, we_n} = c; ba = b; addr = a;
        if (m_pwr == 2'd3 && k) begin
            #1 chk("R10 async exit", pwr_state, 0);
        end
        if (m_pwr == 2'd0) begin
            if (!k) begin
                tag = "R8";
                if (c == C_REF && anyo) begin e_err = 1'b1; tag = "R7"; end
                n_pwr = (c == C_REF && !anyo) ? 2'd3 : (anyo ? 2'd2 : 2'd1);
            end else begin
                case (c)
                    C_ACT: if (m_open[b]) begin e_err = 1'b1; tag = "R7"; end
                           else begin e_stb = 7'd1; tag = "R3"; m_open[b] = 1'b1; m_row[b] = a; end
                    C_RD, C_WR: begin
                        e_addr[10] = 1'b0;
                        if (!m_open[b]) begin e_err = 1'b1; tag = "R7"; end
                        else begin
                            tag = "R4"; e_stb = (c == C_RD) ? 7'd2 : 7'd4; e_ap = a[10];
                            if (a[10]) m_open[b] = 1'b0;
                        end
                    end
                    C_PRE: begin
                        tag = "R5"; e_stb = 7'd8;
                        e_pm = a[10] ? 4'hf : (4'd1 << b);
                        for (int i = 0; i < 4; i++) if (e_pm[i]) m_open[i] = 1'b0;
                    end
                    C_REF: if (anyo) begin e_err = 1'b1; tag = "R7"; end
                           else e_stb = 7'd16;
                    C_LMR: begin tag = "R6"; e_stb = 7'd32; e_mb = ~b[0]; e_me = b[0]; end
                    C_BST: begin tag = "R11"; e_stb = 7'd64; end
                    default: tag = "R2";
                endcase
            end
        end else begin
            tag = (m_pwr == 2'd3) ? "R10" : "R9";
            if (k) n_pwr = 2'd0;
        end
        m_pwr = n_pwr;
        @(posedge clk); #1;
        chk(tag, cmd_stb, e_stb);
        chk(tag, cmd_err, e_err);
        chk(tag, pre_mask, e_pm);
        chk(tag, {auto_pre, mr_base_ld, mr_ext_ld}, {e_ap, e_mb, e_me});
        chk(tag, pwr_state, m_pwr);
        chk(tag, bank_open, open_vec());
        if (e_stb != 0) chk(tag, {cmd_bank, cmd_addr}, {b, e_addr});
        for (int i = 0; i < 4; i++)
            if (m_open[i]) chk(tag, bank_row[i*13 +: 13], m_row[i]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [3:0] codes [9];
        int unsigned seed_val;
        codes = '{C_NOP, C_ACT, C_RD, C_WR, C_PRE, C_REF, C_LMR, C_BST, 4'b1011};
        seed_val = $urandom(32'h5eed);
        do_reset();
        // directed corner cases
        step(1, C_ACT, 2'd0, 13'h0123);          // R3
        step(1, C_ACT, 2'd0, 13'h0456);          // R7 activate to open bank
        step(1, C_RD,  2'd1, 13'h0010);          // R7 read idle bank
        step(1, C_RD,  2'd0, 13'h0020);          // R4 no auto-precharge
        step(1, C_WR,  2'd0, 13'h0430);          // R4 auto-precharge closes
        step(1, C_ACT, 2'd2, 13'h1abc);
        step(1, C_ACT, 2'd3, 13'h0777);
        step(1, C_PRE, 2'd2, 13'h0000);          // R5 single bank
        step(1, C_REF, 2'd0, 13'h0000);          // R7 refresh with open bank
        step(0, C_NOP, 2'd0, 13'h0000);          // R8 active power-down
        step(0, C_ACT, 2'd1, 13'h0001);          // R9 ignored
        step(1, C_ACT, 2'd1, 13'h0002);          // R9 exit edge ignored
        step(1, C_PRE, 2'd0, 13'h0400);          // R5 all banks
        step(1, C_LMR, 2'd0, 13'h0063);          // R6 base
        step(1, C_LMR, 2'd1, 13'h0002);          // R6 extended
        step(1, C_BST, 2'd0, 13'h0000);          // R11
        step(1, 4'b1011, 2'd1, 13'h0005);        // R2 chip select high
        step(0, C_NOP, 2'd0, 13'h0000);          // R8 precharge power-down
        step(1, C_NOP, 2'd0, 13'h0000);
        step(0, C_REF, 2'd0, 13'h0000);          // R8 self-refresh entry
        step(0, C_NOP, 2'd0, 13'h0000);
        step(1, C_ACT, 2'd0, 13'h0009);          // R10 exit, command ignored
        step(1, C_ACT, 2'd1, 13'h0fff);
        do_reset();                              // R1 with an open bank
        // constrained random traffic
        for (int n = 0; n < 4000; n++) begin
            step(($urandom % 8) != 0, codes[$urandom % 9], 2'($urandom), 13'($urandom));
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule